// File: doc/BRIEF.md
# Pulse-Swallow Dual-Modulus Divider Controller

This block sits behind an external dual-modulus prescaler and turns its output into the comparison-rate pulse of a frequency synthesizer loop. Two down-counters run in step on each prescaler output pulse. The main counter sets how many prescaler periods make up one output period. The swallow counter keeps the prescaler in its P+1 mode for the first A of those periods and then drops it back to P. One output period therefore spans P·N + A cycles of the prescaler input clock. P can be 32 or 64 and is chosen on the prescaler side.

The block runs on the prescaler input clock. It receives the prescaler output as a one-cycle enable. A new (N, A) pair is offered together with a load strobe. The pair is checked for legality and held as pending. It goes live only at the next output-period boundary, where both counters reload together, so no period ever mixes two settings. An illegal pair raises an error flag and is dropped, and the running setting stays as it was.

Top module: `psw_divider`

## Requirements
- R1: After reset the active setting is N=16, A=0. mod_hi_o, div_pulse_o and cfg_err_o are all low.
- R2: With the prescaler at P=32, the interval between consecutive div_pulse_o pulses is 32·N + A clock cycles.
- R3: With the prescaler at P=64, the interval between consecutive div_pulse_o pulses is 64·N + A clock cycles.
- R4: In each output period, mod_hi_o (1 = select P+1, 0 = select P) is high for exactly the first A prescaler pulses and low for the remaining N−A.
- R5: div_pulse_o is high for exactly one cycle. It rises the cycle after the prescaler pulse that ends each period of N prescaler pulses.
- R6: With A=0, mod_hi_o stays low for the whole period and the interval is P·N.
- R7: A valid load made in the middle of a period does not change that period. The new setting governs the period that starts at the next div_pulse_o.
- R8: A load with A ≥ N or with N < 16 sets cfg_err_o one cycle after the strobe. The running setting is unchanged in the current period and in later periods.
- R9: A valid load clears cfg_err_o one cycle after the strobe.
- R10: The extremes A = N−1 and A = 127 give the same interval law as R2/R3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Prescaler input (VCO) clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pre_pulse_i | input | 1 | One-cycle enable per prescaler output period |
| n_val_i | input | 11 | Main counter ratio N, offered with load_i |
| a_val_i | input | 7 | Swallow counter ratio A, offered with load_i |
| load_i | input | 1 | One-cycle strobe that offers n_val_i / a_val_i |
| mod_hi_o | output | 1 | Prescaler modulus select: 1 = P+1, 0 = P |
| div_pulse_o | output | 1 | One-cycle pulse per output period |
| cfg_err_o | output | 1 | Last offered setting was rejected |

## Verification
The hardest case to reach is a load that lands inside a running period, followed by the boundary where the pending pair takes over. Reaching it needs a live prescaler loop rather than stand-alone stimulus. The bench therefore closes the loop with a prescaler model that follows mod_hi_o, and it fires the load strobe a fixed number of cycles after a div_pulse_o edge. It then measures that period and the next one separately, so a change applied early, late or in mixed form shows up as a wrong cycle count. Rejected pairs go through the same mid-period route, with a check that the following periods keep the old length.

// File: rtl/psw_pkg.sv
package psw_pkg;
  parameter int unsigned N_W   = 11;
  parameter int unsigned A_W   = 7;
  parameter int unsigned N_MIN = 16;
  parameter int unsigned N_RST = 16;
  parameter int unsigned A_RST = 0;

  typedef struct packed {
    logic [N_W-1:0] n;
    logic [A_W-1:0] a;
  } psw_cfg_t;

  localparam psw_cfg_t CFG_RST = '{n: N_W'(N_RST), a: A_W'(A_RST)};

  function automatic logic cfg_legal(psw_cfg_t c);
    return (c.n >= N_W'(N_MIN)) && (N_W'(c.a) < c.n);
  endfunction
endpackage

// File: rtl/psw_cfg_reg.sv
module psw_cfg_reg
  import psw_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     load_i,
  input  psw_cfg_t cfg_i,
  input  logic     reload_i,
  output psw_cfg_t nxt_o,
  output logic     err_o
);
  psw_cfg_t act_q, pend_q;
  logic     pend_vld_q, err_q;
  logic     legal;

  assign legal = cfg_legal(cfg_i);
  // value the counters take at the next boundary
  assign nxt_o = pend_vld_q ? pend_q : act_q;
  assign err_o = err_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_q      <= CFG_RST;
      pend_q     <= CFG_RST;
      pend_vld_q <= 1'b0;
      err_q      <= 1'b0;
    end else begin
      if (reload_i && pend_vld_q) begin
        act_q      <= pend_q;
        pend_vld_q <= 1'b0;
      end
      if (load_i) begin
        if (legal) begin
          pend_q     <= cfg_i;
          pend_vld_q <= 1'b1;
          err_q      <= 1'b0;
        end else begin
          err_q <= 1'b1;
        end
      end
    end
  end

  a_r7_act_at_boundary: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (act_q != $past(act_q)) |-> $past(reload_i));
  a_r8_reject_flags: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_i && !legal) |=> err_o);
  a_r8_reject_no_pend: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_i && !legal && !pend_vld_q) |=> !pend_vld_q);
  a_r9_accept_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_i && legal) |=> !err_o);
endmodule

// File: rtl/psw_swallow_cnt.sv
module psw_swallow_cnt
  import psw_pkg::*;
(
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           pulse_i,
  input  logic           reload_i,
  input  logic [A_W-1:0] a_load_i,
  output logic           mod_hi_o
);
  logic [A_W-1:0] a_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                   a_q <= A_W'(A_RST);
    else if (reload_i)             a_q <= a_load_i;
    else if (pulse_i && a_q != '0) a_q <= a_q - 1'b1;
  end

  assign mod_hi_o = (a_q != '0);

  a_r4_hold_between_pulses: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!pulse_i && !reload_i) |=> $stable(a_q));
endmodule

// File: rtl/psw_main_cnt.sv
module psw_main_cnt
  import psw_pkg::*;
(
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           pulse_i,
  input  logic [N_W-1:0] n_load_i,
  output logic           reload_o,
  output logic           div_pulse_o
);
  logic [N_W-1:0] n_q;
  logic           div_q;

  assign reload_o = pulse_i && (n_q == N_W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      n_q   <= N_W'(N_RST);
      div_q <= 1'b0;
    end else begin
      div_q <= reload_o;
      if (reload_o)     n_q <= n_load_i;
      else if (pulse_i) n_q <= n_q - 1'b1;
    end
  end

  assign div_pulse_o = div_q;

  a_r5_single_cycle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    div_pulse_o |=> !div_pulse_o);
  a_r2_no_underflow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    n_q != '0);
endmodule

// File: rtl/psw_divider.sv
module psw_divider
  import psw_pkg::*;
(
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           pre_pulse_i,
  input  logic [N_W-1:0] n_val_i,
  input  logic [A_W-1:0] a_val_i,
  input  logic           load_i,
  output logic           mod_hi_o,
  output logic           div_pulse_o,
  output logic           cfg_err_o
);
  psw_cfg_t cfg_in, cfg_nxt;
  logic     reload;

  assign cfg_in = '{n: n_val_i, a: a_val_i};

  psw_cfg_reg u_cfg (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .load_i   (load_i),
    .cfg_i    (cfg_in),
    .reload_i (reload),
    .nxt_o    (cfg_nxt),
    .err_o    (cfg_err_o)
  );

  psw_main_cnt u_main (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .pulse_i     (pre_pulse_i),
    .n_load_i    (cfg_nxt.n),
    .reload_o    (reload),
    .div_pulse_o (div_pulse_o)
  );

  psw_swallow_cnt u_swal (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .pulse_i  (pre_pulse_i),
    .reload_i (reload),
    .a_load_i (cfg_nxt.a),
    .mod_hi_o (mod_hi_o)
  );

  a_r4_mod_fall_on_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(mod_hi_o) |-> $past(pre_pulse_i));
  a_r4_mod_rise_on_boundary: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(mod_hi_o) |-> $past(reload));
endmodule

// File: tb/psw_divider_tb.sv
module psw_divider_tb;
  localparam int CLK_PERIOD = 10;
  localparam int WDOG_CYC   = 190000;
  localparam int NVEC       = 6;
  // {P, N, A}
  localparam int VEC [NVEC][3] = '{
    '{32, 16, 0}, '{32, 16, 15}, '{64, 20, 5},
    '{64, 100, 37}, '{32, 300, 127}, '{64, 40, 0}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        load = 1'b0;
  logic [10:0] n_val = '0;
  logic [6:0]  a_val = '0;
  logic        mod_hi, div_pulse, cfg_err, ps_pulse;
  int unsigned p_sel = 32;
  int unsigned ps_cnt;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  // prescaler model: P+1 or P input cycles per output pulse
  assign ps_pulse = ps_cnt >= (mod_hi ? p_sel : p_sel - 1);
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n)        ps_cnt <= 0;
    else if (ps_pulse) ps_cnt <= 0;
    else               ps_cnt <= ps_cnt + 1;
  end

  psw_divider u_dut (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .pre_pulse_i (ps_pulse),
    .n_val_i     (n_val),
    .a_val_i     (a_val),
    .load_i      (load),
    .mod_hi_o    (mod_hi),
    .div_pulse_o (div_pulse),
    .cfg_err_o   (cfg_err)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // waits for a div pulse, then counts the cycles to the next one;
  // optionally offers (ln, la) 20 cycles into that period
  task automatic measure(input bit do_ld, input int ln, input int la,
                         output int cyc, output int hi, output int err_after);
    do @(negedge clk); while (!div_pulse);
    cyc = 0; hi = 0; err_after = -1;
    forever begin
      @(negedge clk);
      cyc++;
      if (ps_pulse && mod_hi) hi++;
      if (do_ld && cyc == 20) begin
        n_val = 11'(ln); a_val = 7'(la); load = 1'b1;
      end
      if (do_ld && cyc == 21) begin
        load = 1'b0;
        err_after = int'(cfg_err);
      end
      if (div_pulse) break;
    end
  endtask

  task automatic load_now(input int ln, input int la);
    @(negedge clk);
    n_val = 11'(ln); a_val = 7'(la); load = 1'b1;
    @(negedge clk);
    load = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * WDOG_CYC);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual expired expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int cyc, hi, ea;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 mod_hi after reset", int'(mod_hi), 0);
    chk("R1 div_pulse after reset", int'(div_pulse), 0);
    chk("R1 cfg_err after reset", int'(cfg_err), 0);
    measure(1'b0, 0, 0, cyc, hi, ea);
    chk("R1 reset period 32*16", cyc, 512);

    for (int v = 0; v < NVEC; v++) begin
      int p, n, a;
      p = VEC[v][0]; n = VEC[v][1]; a = VEC[v][2];
      p_sel = p;
      load_now(n, a);
      measure(1'b0, 0, 0, cyc, hi, ea);
      if (p == 32) chk($sformatf("R2 period N=%0d A=%0d", n, a), cyc, p*n + a);
      else         chk($sformatf("R3 period N=%0d A=%0d", n, a), cyc, p*n + a);
      if (a == 0)  chk("R6 no P+1 periods with A=0", hi, 0);
      else         chk($sformatf("R4 P+1 pulses A=%0d", a), hi, a);
      @(negedge clk);
      chk("R5 pulse one cycle wide", int'(div_pulse), 0);
    end

    // R10: A = N-1 at the minimum N
    p_sel = 32;
    load_now(16, 15);
    measure(1'b0, 0, 0, cyc, hi, ea);
    chk("R10 A=N-1 period", cyc, 32*16 + 15);
    chk("R10 A=N-1 P+1 pulses", hi, 15);

    // R7: mid-period load keeps the running period
    load_now(16, 0);
    measure(1'b0, 0, 0, cyc, hi, ea);
    measure(1'b1, 50, 10, cyc, hi, ea);
    chk("R7 period with mid load stays old", cyc, 512);
    chk("R9 valid load err low", ea, 0);
    measure(1'b0, 0, 0, cyc, hi, ea);
    chk("R7 next period uses new", cyc, 32*50 + 10);

    // R8: illegal pairs rejected, setting kept
    measure(1'b1, 20, 20, cyc, hi, ea);
    chk("R8 A>=N flags err", ea, 1);
    chk("R8 period unchanged after A>=N", cyc, 1610);
    measure(1'b0, 0, 0, cyc, hi, ea);
    chk("R8 later period unchanged", cyc, 1610);
    chk("R8 err stays set", int'(cfg_err), 1);
    measure(1'b1, 10, 3, cyc, hi, ea);
    chk("R8 N<16 flags err", ea, 1);
    measure(1'b0, 0, 0, cyc, hi, ea);
    chk("R8 period unchanged after N<16", cyc, 1610);

    // R9: valid load clears the flag
    measure(1'b1, 17, 1, cyc, hi, ea);
    chk("R9 err cleared by valid load", ea, 0);
    measure(1'b0, 0, 0, cyc, hi, ea);
    chk("R9 accepted setting applied", cyc, 32*17 + 1);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule